// File: doc/BRIEF.md
# Per-Lane FEC Request Handshake for Link Training

This block sits beside one lane of a link-training sequencer. It lets each receiver decide for itself whether forward error correction is needed, after equalization has had a chance to settle. That decision is carried to the link partner inside the status report word of every outgoing training frame. The partner's own decision arrives the same way in incoming frames. FEC is therefore chosen separately for each direction once training has finished, and not fixed beforehand during negotiation.

The sequencer has three phases: sending training, training the remote side, and link ready. When the local receiver reports that it is trained, the local request is frozen into a "FEC needed locally" flag. When the partner reports that its receiver is ready, the partner's most recently received request is frozen into a "FEC needed remotely" flag. A training restart, for example on link loss, returns the lane to the first phase and clears both flags.

Top module: `fec_hs_lane`

## Requirements
- R1: While reset is asserted (rstN low), trainPhase is 0, both flags are 0 and txStatusWord is all zero.
- R2: trainPhase encodes sending training as 0, training remote as 1 and link ready as 2. From phase 0, rxTrained moves the lane to phase 1 at the next edge. From phase 1, remoteRxReady moves it to phase 2. remoteRxReady has no effect in phase 0, and phase 2 holds until a restart.
- R3: restartReq high at an edge sends the lane to phase 0 and clears both flags, whatever the phase and the other inputs.
- R4: localFecOn reads 0 until the edge that enters phase 1. At that edge it takes the value of localFecReq, and it keeps that value until the next restart.
- R5: remoteFecOn reads 0 until the edge that enters phase 2. At that edge it takes the partner request most recently received. A valid word arriving in that same cycle takes precedence.
- R6: The partner request is bit 14 of rxStatusWord. It is captured only in cycles with rxWordValid high, and it holds between valid words. A restart clears it to 0.
- R7: Bit 14 of txStatusWord equals localFecReq as sampled at the previous clock edge (1 asks the partner to enable FEC on its transmitter).
- R8: Bits 13 to 6 of txStatusWord are reserved and read 0. Bits 5 to 0 also read 0.
- R9: Bit 15 of txStatusWord is 1 exactly when trainPhase is not 0 (the local receiver is trained).
- R10: In phase 2, changes to localFecReq and newly received partner requests leave both flags unchanged until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restartReq | input | 1 | Training restart or link-down strobe |
| localFecReq | input | 1 | Local receiver wants FEC on the partner transmitter |
| rxWordValid | input | 1 | rxStatusWord belongs to a valid received frame |
| rxStatusWord | input | 16 | Received status report word |
| rxTrained | input | 1 | Local receiver adaptation has finished |
| remoteRxReady | input | 1 | Partner reports its receiver is ready |
| txStatusWord | output | 16 | Status report word to transmit |
| localFecOn | output | 1 | Latched: FEC needed on the receive path of this lane |
| remoteFecOn | output | 1 | Latched: partner needs FEC from the local transmitter |
| trainPhase | output | 2 | Current sequencer phase |

## Verification
A wrong phase shows one edge later, either on trainPhase or on bit 15 of the transmitted word. A flag latched at the wrong time, or with a stale request, shows on localFecOn or remoteFecOn at the edge where the phase changes. The hardest faults to see are a request register that captures invalid words and flags that keep following their inputs after they were frozen. These stay hidden until the next phase entry or until a late input change. Directed sequences therefore change the requests in those windows, and a random run repeats this under frequent restarts.

// File: rtl/fec_hs_pkg.sv
package fec_hs_pkg;

  typedef enum logic [1:0] {
    PH_SEND         = 2'd0,
    PH_TRAIN_REMOTE = 2'd1,
    PH_LINK_READY   = 2'd2
  } phase_e;

  // Strobes from the sequencer to the flag datapath
  typedef struct packed {
    logic enterSend;    // restart or illegal state: clear everything
    logic enterRemote;  // freeze local request
    logic enterReady;   // freeze partner request
    logic capValid;     // accept request bit of the current received word
  } hsStrobe_t;

endpackage

// File: rtl/fec_hs_ctrl.sv
module fec_hs_ctrl
  import fec_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      restartReq,
  input  logic      rxTrained,
  input  logic      remoteRxReady,
  input  logic      rxWordValid,
  output phase_e    phase,
  output hsStrobe_t strobe
);

  phase_e phaseNxt;

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    if (restartReq) begin
      phaseNxt         = PH_SEND;
      strobe.enterSend = 1'b1;
    end else begin
      unique case (phase)
        PH_SEND: begin
          if (rxTrained) begin
            phaseNxt           = PH_TRAIN_REMOTE;
            strobe.enterRemote = 1'b1;
          end
        end
        PH_TRAIN_REMOTE: begin
          if (remoteRxReady) begin
            phaseNxt          = PH_LINK_READY;
            strobe.enterReady = 1'b1;
          end
        end
        PH_LINK_READY: phaseNxt = PH_LINK_READY;
        default: begin
          phaseNxt         = PH_SEND;
          strobe.enterSend = 1'b1;
        end
      endcase
    end
    strobe.capValid = rxWordValid & ~restartReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_SEND;
    else       phase <= phaseNxt;
  end

endmodule

// File: rtl/fec_hs_dp.sv
module fec_hs_dp
  import fec_hs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int REQ_BIT   = 14,
  parameter int READY_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobe_t         strobe,
  input  phase_e            phase,
  input  logic              localFecReq,
  input  logic [WORD_W-1:0] rxStatusWord,
  output logic [WORD_W-1:0] txStatusWord,
  output logic              localFecOn,
  output logic              remoteFecOn
);

  logic              rxReqBit;
  logic              remoteReqQ;
  logic              localReqQ;
  logic              trainedBit;
  logic [WORD_W-1:0] unusedRxWord;

  assign unusedRxWord = rxStatusWord;
  assign rxReqBit     = rxStatusWord[REQ_BIT];
  assign trainedBit   = (phase != PH_SEND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localFecOn  <= 1'b0;
      remoteFecOn <= 1'b0;
      remoteReqQ  <= 1'b0;
      localReqQ   <= 1'b0;
    end else begin
      localReqQ <= localFecReq;
      if (strobe.enterSend) begin
        localFecOn  <= 1'b0;
        remoteFecOn <= 1'b0;
        remoteReqQ  <= 1'b0;
      end else begin
        if (strobe.enterRemote) localFecOn <= localFecReq;
        if (strobe.enterReady)
          remoteFecOn <= strobe.capValid ? rxReqBit : remoteReqQ;
        if (strobe.capValid) remoteReqQ <= rxReqBit;
      end
    end
  end

  // Outgoing word: request and trained bits placed, every other bit zero
  for (genvar i = 0; i < WORD_W; i++) begin : g_txBit
    if (i == REQ_BIT) begin : g_req
      assign txStatusWord[i] = localReqQ;
    end else if (i == READY_BIT) begin : g_rdy
      assign txStatusWord[i] = trainedBit;
    end else begin : g_zero
      assign txStatusWord[i] = 1'b0;
    end
  end

endmodule

// File: rtl/fec_hs_lane.sv
module fec_hs_lane
  import fec_hs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int REQ_BIT   = 14,
  parameter int READY_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartReq,
  input  logic              localFecReq,
  input  logic              rxWordValid,
  input  logic [WORD_W-1:0] rxStatusWord,
  input  logic              rxTrained,
  input  logic              remoteRxReady,
  output logic [WORD_W-1:0] txStatusWord,
  output logic              localFecOn,
  output logic              remoteFecOn,
  output logic [1:0]        trainPhase
);

  phase_e    phase;
  hsStrobe_t strobe;

  fec_hs_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .restartReq   (restartReq),
    .rxTrained    (rxTrained),
    .remoteRxReady(remoteRxReady),
    .rxWordValid  (rxWordValid),
    .phase        (phase),
    .strobe       (strobe)
  );

  fec_hs_dp #(
    .WORD_W   (WORD_W),
    .REQ_BIT  (REQ_BIT),
    .READY_BIT(READY_BIT)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .phase       (phase),
    .localFecReq (localFecReq),
    .rxStatusWord(rxStatusWord),
    .txStatusWord(txStatusWord),
    .localFecOn  (localFecOn),
    .remoteFecOn (remoteFecOn)
  );

  assign trainPhase = phase;

endmodule

// File: rtl/fec_hs_chk.sv
module fec_hs_chk #(
  parameter int WORD_W    = 16,
  parameter int REQ_BIT   = 14,
  parameter int READY_BIT = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              restartReq,
  input logic              localFecReq,
  input logic              rxTrained,
  input logic [WORD_W-1:0] txStatusWord,
  input logic              localFecOn,
  input logic              remoteFecOn,
  input logic [1:0]        trainPhase
);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> (trainPhase == 2'd0) && !localFecOn && !remoteFecOn); // R3

  AST_ENTER_REMOTE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (trainPhase == 2'd0) && rxTrained && !restartReq
      |=> (trainPhase == 2'd1) && (localFecOn == $past(localFecReq))); // R4

  AST_LOCAL_OFF_SENDING: assert property (@(posedge clk) disable iff (!rstN)
    (trainPhase == 2'd0) |-> !localFecOn); // R4

  AST_REMOTE_OFF_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (trainPhase != 2'd2) |-> !remoteFecOn); // R5

  AST_TX_REQ_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> txStatusWord[REQ_BIT] == $past(localFecReq)); // R7

  AST_TX_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    txStatusWord[13:0] == 14'd0); // R8

  AST_TX_READY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    txStatusWord[READY_BIT] == (trainPhase != 2'd0)); // R9

  AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (trainPhase == 2'd2) && !restartReq
      |=> $stable(localFecOn) && $stable(remoteFecOn) && (trainPhase == 2'd2)); // R10

endmodule

bind fec_hs_lane fec_hs_chk #(
  .WORD_W   (WORD_W),
  .REQ_BIT  (REQ_BIT),
  .READY_BIT(READY_BIT)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .restartReq  (restartReq),
  .localFecReq (localFecReq),
  .rxTrained   (rxTrained),
  .txStatusWord(txStatusWord),
  .localFecOn  (localFecOn),
  .remoteFecOn (remoteFecOn),
  .trainPhase  (trainPhase)
);

// File: tb/test_fec_hs_lane.sv
module test_fec_hs_lane;

  logic        clk = 1'b0;
  logic        rstN;
  logic        restartReq, localFecReq, rxWordValid, rxTrained, remoteRxReady;
  logic [15:0] rxStatusWord;
  logic [15:0] txStatusWord;
  logic        localFecOn, remoteFecOn;
  logic [1:0]  trainPhase;

  int checks   = 0;
  int failures = 0;

  // reference model state
  logic [1:0] mPhase;
  logic       mLocal, mRemote, mReq, mTx14;

  always #2.5 clk = ~clk;

  fec_hs_lane i_fec_hs_lane (
    .clk(clk), .rstN(rstN), .restartReq(restartReq), .localFecReq(localFecReq),
    .rxWordValid(rxWordValid), .rxStatusWord(rxStatusWord), .rxTrained(rxTrained),
    .remoteRxReady(remoteRxReady), .txStatusWord(txStatusWord),
    .localFecOn(localFecOn), .remoteFecOn(remoteFecOn), .trainPhase(trainPhase)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] nextPhase(input logic [1:0] ph);
    if (restartReq) return 2'd0;
    if (ph == 2'd0 && rxTrained) return 2'd1;
    if (ph == 2'd1 && remoteRxReady) return 2'd2;
    return ph;
  endfunction

  task automatic compareAll();
    chk("R2 phase", {30'd0, trainPhase}, {30'd0, mPhase});
    chk("R4 localFecOn", {31'd0, localFecOn}, {31'd0, mLocal});
    chk("R5 remoteFecOn", {31'd0, remoteFecOn}, {31'd0, mRemote});
    chk("R7 tx request bit", {31'd0, txStatusWord[14]}, {31'd0, mTx14});
    chk("R8 tx zero bits", {18'd0, txStatusWord[13:0]}, 32'd0);
    chk("R9 tx trained bit", {31'd0, txStatusWord[15]}, {31'd0, (mPhase != 2'd0)});
  endtask

  task automatic tick();
    logic [1:0] np;
    @(posedge clk);
    np = nextPhase(mPhase);
    if (restartReq) begin
      mLocal = 1'b0; mRemote = 1'b0; mReq = 1'b0;
    end else begin
      if (mPhase == 2'd0 && np == 2'd1) mLocal = localFecReq;
      if (mPhase == 2'd1 && np == 2'd2) mRemote = rxWordValid ? rxStatusWord[14] : mReq;
      if (rxWordValid) mReq = rxStatusWord[14];
    end
    mTx14  = localFecReq;
    mPhase = np;
    #1;
    compareAll();
  endtask

  task automatic idle();
    restartReq = 0; rxWordValid = 0; rxTrained = 0; remoteRxReady = 0;
    rxStatusWord = 16'h0000;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; idle(); localFecReq = 1'b0;
    mPhase = 0; mLocal = 0; mRemote = 0; mReq = 0; mTx14 = 0;
    #12;
    chk("R1 reset phase", {30'd0, trainPhase}, 32'd0);
    chk("R1 reset localFecOn", {31'd0, localFecOn}, 32'd0);
    chk("R1 reset remoteFecOn", {31'd0, remoteFecOn}, 32'd0);
    chk("R1 reset tx word", {16'd0, txStatusWord}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    #1;

    // Scenario A: local request latched, invalid word ignored, freeze in ready
    localFecReq = 1; tick();
    rxTrained = 1; tick();
    chk("R4 latch on phase 1 entry", {31'd0, localFecOn}, 32'd1);
    rxTrained = 0; localFecReq = 0; tick();
    chk("R4 held after request drop", {31'd0, localFecOn}, 32'd1);
    rxStatusWord = 16'h4000; rxWordValid = 0; tick();
    rxStatusWord = 16'h0000; remoteRxReady = 1; tick();
    chk("R6 invalid word not captured", {31'd0, remoteFecOn}, 32'd0);
    chk("R2 phase 2 reached", {30'd0, trainPhase}, 32'd2);
    remoteRxReady = 0;
    for (int k = 0; k < 6; k++) begin
      localFecReq = k[0]; rxWordValid = 1; rxStatusWord = 16'h4000; tick();
    end
    chk("R10 localFecOn frozen", {31'd0, localFecOn}, 32'd1);
    chk("R10 remoteFecOn frozen", {31'd0, remoteFecOn}, 32'd0);
    idle(); restartReq = 1; rxTrained = 1; tick();
    chk("R3 restart clears local", {31'd0, localFecOn}, 32'd0);
    chk("R3 restart wins over rxTrained", {30'd0, trainPhase}, 32'd0);

    // Scenario B: ready ignored in phase 0, same-cycle word wins
    idle(); remoteRxReady = 1; tick();
    chk("R2 remoteRxReady ignored in phase 0", {30'd0, trainPhase}, 32'd0);
    idle(); localFecReq = 0; rxTrained = 1; tick();
    chk("R4 latch of zero request", {31'd0, localFecOn}, 32'd0);
    idle(); rxWordValid = 1; rxStatusWord = 16'h0000; tick();
    rxStatusWord = 16'h4000; remoteRxReady = 1; tick();
    chk("R5 same-cycle word wins", {31'd0, remoteFecOn}, 32'd1);
    idle(); restartReq = 1; tick();
    chk("R3 restart clears remote", {31'd0, remoteFecOn}, 32'd0);

    // Scenario C: captured request held across gaps between frames
    idle(); rxTrained = 1; tick();
    idle(); rxWordValid = 1; rxStatusWord = 16'hC000; tick();
    idle(); rxStatusWord = 16'h0000; tick(); tick();
    remoteRxReady = 1; tick();
    chk("R6 request held between frames", {31'd0, remoteFecOn}, 32'd1);
    idle(); restartReq = 1; tick();
    idle();

    // Random phase
    for (int n = 0; n < 5000; n++) begin
      restartReq    = ($urandom % 40) == 0;
      rxTrained     = ($urandom % 5) == 0;
      remoteRxReady = ($urandom % 5) == 0;
      rxWordValid   = ($urandom % 3) != 0;
      rxStatusWord  = 16'($urandom);
      if (($urandom % 4) == 0) localFecReq = ~localFecReq;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule